// File: doc/BRIEF.md
# SCSI Initiator Information-Transfer Sequencer

This block is the initiator-side engine for a single information-transfer command on a SCSI bus. It moves bytes with the asynchronous REQ/ACK handshake. Inbound bytes go from the bus into a byte FIFO, and outbound bytes go from that FIFO onto the bus. It drives ACK and ATN and decodes the target's phase lines. It checks odd parity on inbound bytes and generates odd parity on outbound bytes.

A host starts a command by writing a command code. A command ends when the target changes phase early, when the byte budget is used up, or when a bus-reset command is written. Each way of ending sets a cause bit in a sticky status vector. The command register reads back as zero once the command has ended.

Three termination rules are specific to this block. ATN is dropped a full cycle before ACK on the last Message Out byte. ACK stays held after the last Message In byte so that the host can accept or reject the message. On an inbound byte with bad parity, ATN is raised before ACK is released.

Top module: `scsi_init_xfer`

## Requirements
- R1: After reset, ack_o, atn_o, rst_bus_o, data_oe_o, fifo_push_o, fifo_pop_o and irq_o are low, and cmd_reg_o and status_o are zero.
- R2: A write whose low seven bits are 0x10 starts a transfer, but only while idle. A write whose low seven bits are 0x03 is a bus reset and is taken in any state. Bit 7 selects DMA mode. An accepted code shows on cmd_reg_o from the next cycle. Any other code, and a transfer code written while busy, leave cmd_reg_o unchanged.
- R3: Phase is the 3-bit value {msg_i,cd_i,io_i}: 000 data out, 001 data in, 011 status, 110 message out, 111 message in. When io_i=1, each sampled REQ pushes data_i into the FIFO and raises ACK on the next cycle. ACK falls the cycle after REQ is seen low.
- R4: When io_i=0, each REQ pops the FIFO head and drives it on data_o with odd parity and data_oe_o high. ACK rises one cycle later. While the FIFO is empty the REQ waits and ACK stays low.
- R5: In DMA mode the byte count from cmd_count_i sets the last byte. Without DMA, an outbound transfer ends on the byte popped at FIFO level 1, and an inbound transfer moves one byte.
- R6: A REQ whose phase differs from the first byte's phase moves no byte and raises no ACK. It clears cmd_reg_o and sets the service-request bit.
- R7: When a transfer that is not in Message In finishes, ACK is released and cmd_reg_o clears. The service-request bit is set only when the target next asserts REQ.
- R8: atn_set_i raises ATN. On the last Message Out byte, ATN is low for at least one full cycle before ACK rises.
- R9: After the last Message In byte, ACK stays high once REQ falls, the success bit is set and cmd_reg_o clears. The next accepted command releases ACK.
- R10: When parity_en_i is set, an inbound byte with even overall parity raises ATN no later than ACK and sets the parity bit. When parity_en_i is clear, such a byte changes neither ATN nor the parity bit.
- R11: A bus-reset command drops ACK, ATN and data_oe_o at once and drives rst_bus_o for RST_CYC cycles. It sets the reset bit unless rst_irq_dis_i is high. When rst_bus_o ends, cmd_reg_o reads zero.
- R12: status_o bits are success (0), service request (1), bus reset (2) and parity error (3). Each bit stays set until status_rd_i clears all of them. irq_o is high exactly when status_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command code; bit 7 selects DMA |
| cmd_count_i | input | CNT_W | Byte count for DMA mode |
| parity_en_i | input | 1 | Enable inbound parity checking |
| rst_irq_dis_i | input | 1 | Suppress the bus-reset status bit |
| atn_set_i | input | 1 | Host request to raise ATN |
| status_rd_i | input | 1 | Status read strobe; clears all bits |
| req_i | input | 1 | Target REQ |
| msg_i | input | 1 | Target MSG phase line |
| cd_i | input | 1 | Target C/D phase line |
| io_i | input | 1 | Target I/O phase line |
| data_i | input | DATA_W | Bus data from the target |
| data_par_i | input | 1 | Bus parity from the target |
| ack_o | output | 1 | Initiator ACK |
| atn_o | output | 1 | Initiator ATN |
| rst_bus_o | output | 1 | Bus reset drive |
| data_o | output | DATA_W | Bus data to the target |
| data_par_o | output | 1 | Odd parity of data_o |
| data_oe_o | output | 1 | Enable for the bus data drivers |
| fifo_push_o | output | 1 | Push an inbound byte |
| fifo_wdata_o | output | DATA_W | Inbound byte to the FIFO |
| fifo_pop_o | output | 1 | Pop the FIFO head |
| fifo_rdata_i | input | DATA_W | FIFO head, show-ahead |
| fifo_empty_i | input | 1 | FIFO is empty |
| fifo_level_i | input | LVL_W | FIFO fill level |
| cmd_reg_o | output | 8 | Command register |
| status_o | output | 4 | Sticky cause bits |
| irq_o | output | 1 | Interrupt, OR of the status bits |

## Verification
The bench checks that the last Message Out byte drops ATN a cycle ahead of ACK. A design that drops both on the same edge would let the target read the ATN request as still pending. It checks that ACK stays held after the last Message In byte and is released by the next command; a design that got this wrong would let the target run on before the host can reject the message. A phase change on a pending REQ must neither push nor acknowledge a byte, or the FIFO would take in a status byte as data. The bench also times a bus reset in the middle of a handshake and tests parity errors with checking on and off; a wrong design would leave ACK high on a reset bus or raise ATN for a byte that checking should have ignored.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;
  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;
  localparam logic [2:0] PH_STAT = 3'b011;
  localparam logic [2:0] PH_MOUT = 3'b110;
  localparam logic [2:0] PH_MIN  = 3'b111;

  localparam logic [6:0] OP_XFER = 7'h10;
  localparam logic [6:0] OP_BRST = 7'h03;

  localparam int ST_W      = 4;
  localparam int SB_OK     = 0;
  localparam int SB_SRV    = 1;
  localparam int SB_RST    = 2;
  localparam int SB_PAR    = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_REQ, S_DRIVE, S_ACK, S_DONE, S_RESET
  } seq_state_e;
endpackage

// File: rtl/scsi_bus_if.sv
module scsi_bus_if #(
  parameter int DATA_W = 8
) (
  input  logic              msg_i,
  input  logic              cd_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [2:0]        phase_o,
  output logic              inbound_o,
  output logic              rx_par_err_o,
  output logic              tx_par_o
);
  assign phase_o      = {msg_i, cd_i, io_i};
  assign inbound_o    = io_i;
  // odd parity: data plus parity bit must hold an odd number of ones
  assign rx_par_err_o = ~(^{rx_data_i, rx_par_i});
  assign tx_par_o     = ~(^tx_data_i);
endmodule

// File: rtl/scsi_xfer_cnt.sv
module scsi_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // a count of zero behaves like a count of one
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/scsi_irq_stat.sv
module scsi_irq_stat #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= '0;
    else if (clr_i)  stat_q <= set_i;
    else             stat_q <= stat_q | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/scsi_rst_timer.sv
module scsi_rst_timer #(
  parameter int RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(RST_CYC + 1);
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= '0;
    else if (start_i)       tmr_q <= TW'(RST_CYC);
    else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign busy_o = (tmr_q != '0);
  assign done_o = (tmr_q == TW'(1)) && !start_i;
endmodule

// File: rtl/scsi_init_xfer.sv
module scsi_init_xfer
  import scsi_xfer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int LVL_W   = 5,
  parameter int RST_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [7:0]        cmd_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic              parity_en_i,
  input  logic              rst_irq_dis_i,
  input  logic              atn_set_i,
  input  logic              status_rd_i,
  input  logic              req_i,
  input  logic              msg_i,
  input  logic              cd_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_par_i,
  output logic              ack_o,
  output logic              atn_o,
  output logic              rst_bus_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_par_o,
  output logic              data_oe_o,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_pop_o,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic              fifo_empty_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  output logic [7:0]        cmd_reg_o,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  seq_state_e        st_q;
  logic [7:0]        cmd_q;
  logic              dma_q, first_q, last_q, ack_q, atn_q, oe_q;
  logic [2:0]        ph_q;
  logic [DATA_W-1:0] dout_q;

  logic [2:0] phase;
  logic       inbound, rx_par_err, tx_par;
  logic       cnt_last, rst_busy, rst_done;

  scsi_bus_if #(.DATA_W(DATA_W)) u_bus (
    .msg_i(msg_i), .cd_i(cd_i), .io_i(io_i),
    .rx_data_i(data_i), .rx_par_i(data_par_i), .tx_data_i(dout_q),
    .phase_o(phase), .inbound_o(inbound),
    .rx_par_err_o(rx_par_err), .tx_par_o(tx_par)
  );

  // command decode
  logic cmd_rst, cmd_xfer, start_xfer;
  assign cmd_rst    = cmd_wr_i && (cmd_i[6:0] == OP_BRST);
  assign cmd_xfer   = cmd_wr_i && (cmd_i[6:0] == OP_XFER);
  assign start_xfer = cmd_xfer && (st_q == S_IDLE);

  // handshake events, bus reset has priority over all of them
  logic req_seen, ph_chg, ev_xfer, ev_rel, ev_min_end, ev_done, last_now;
  assign req_seen   = (st_q == S_WAIT_REQ) && req_i && !cmd_rst;
  assign ph_chg     = req_seen && !first_q && (phase != ph_q);
  assign ev_xfer    = req_seen && !ph_chg && (inbound || !fifo_empty_i);
  assign ev_rel     = (st_q == S_ACK) && !req_i && !cmd_rst;
  assign ev_min_end = ev_rel && last_q && (ph_q == PH_MIN);
  assign ev_done    = (st_q == S_DONE) && req_i && !cmd_rst;

  always_comb begin
    if (dma_q)        last_now = cnt_last;
    else if (inbound) last_now = 1'b1;
    else              last_now = (fifo_level_i == LVL_W'(1));
  end

  scsi_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(start_xfer), .load_val_i(cmd_count_i),
    .dec_i(ev_xfer && dma_q), .last_o(cnt_last)
  );

  scsi_rst_timer #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd_rst),
    .busy_o(rst_busy), .done_o(rst_done)
  );

  logic [ST_W-1:0] stat_set;
  always_comb begin
    stat_set         = '0;
    stat_set[SB_OK]  = ev_min_end;
    stat_set[SB_SRV] = ph_chg || ev_done;
    stat_set[SB_RST] = cmd_rst && !rst_irq_dis_i;
    stat_set[SB_PAR] = ev_xfer && inbound && parity_en_i && rx_par_err;
  end

  scsi_irq_stat #(.N(ST_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stat_set),
    .clr_i(status_rd_i), .stat_o(status_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cmd_q   <= '0;
      dma_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
      atn_q   <= 1'b0;
      oe_q    <= 1'b0;
      ph_q    <= '0;
      dout_q  <= '0;
    end else if (cmd_rst) begin
      st_q  <= S_RESET;
      cmd_q <= cmd_i;
      ack_q <= 1'b0;
      atn_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (atn_set_i) atn_q <= 1'b1;
      unique case (st_q)
        S_IDLE: begin
          if (cmd_xfer) begin
            cmd_q   <= cmd_i;
            dma_q   <= cmd_i[7];
            first_q <= 1'b1;
            ack_q   <= 1'b0;  // releases a held Message In ACK
            st_q    <= S_WAIT_REQ;
          end
        end
        S_WAIT_REQ: begin
          if (ph_chg) begin
            cmd_q <= '0;
            oe_q  <= 1'b0;
            st_q  <= S_IDLE;
          end else if (ev_xfer) begin
            ph_q    <= phase;
            first_q <= 1'b0;
            last_q  <= last_now;
            if (inbound) begin
              ack_q <= 1'b1;
              if (parity_en_i && rx_par_err) atn_q <= 1'b1;
              st_q  <= S_ACK;
            end else begin
              dout_q <= fifo_rdata_i;
              oe_q   <= 1'b1;
              // ATN must fall ahead of ACK on the final message byte
              if (last_now && phase == PH_MOUT) atn_q <= 1'b0;
              st_q   <= S_DRIVE;
            end
          end
        end
        S_DRIVE: begin
          ack_q <= 1'b1;
          st_q  <= S_ACK;
        end
        S_ACK: begin
          if (ev_rel) begin
            if (last_q) begin
              cmd_q <= '0;
              oe_q  <= 1'b0;
              if (ph_q == PH_MIN) begin
                st_q <= S_IDLE;  // ACK held for host inspection
              end else begin
                ack_q <= 1'b0;
                st_q  <= S_DONE;
              end
            end else begin
              ack_q <= 1'b0;
              st_q  <= S_WAIT_REQ;
            end
          end
        end
        S_DONE: begin
          if (ev_done) st_q <= S_IDLE;
        end
        S_RESET: begin
          if (rst_done) begin
            cmd_q <= '0;
            st_q  <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o        = ack_q;
  assign atn_o        = atn_q;
  assign rst_bus_o    = rst_busy;
  assign data_o       = dout_q;
  assign data_par_o   = tx_par;
  assign data_oe_o    = oe_q;
  assign fifo_push_o  = ev_xfer && inbound;
  assign fifo_wdata_o = data_i;
  assign fifo_pop_o   = ev_xfer && !inbound;
  assign cmd_reg_o    = cmd_q;
endmodule

// File: rtl/scsi_init_xfer_chk.sv
module scsi_init_xfer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic [7:0]        cmd_i,
  input logic              parity_en_i,
  input logic              status_rd_i,
  input logic              req_i,
  input logic              io_i,
  input logic [DATA_W-1:0] data_i,
  input logic              data_par_i,
  input logic              ack_o,
  input logic              atn_o,
  input logic              rst_bus_o,
  input logic              data_oe_o,
  input logic              fifo_push_o,
  input logic              fifo_pop_o,
  input logic              fifo_empty_i,
  input logic [3:0]        status_o
);
  logic rst_cmd;
  assign rst_cmd = cmd_wr_i && (cmd_i[6:0] == 7'h03);

  a_r11_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_bus_o |-> (!ack_o && !data_oe_o));

  a_r3_push_inbound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> (io_i && req_i));

  a_r4_pop_outbound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (!io_i && !fifo_empty_i));

  a_r10_par_atn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push_o && parity_en_i && !(^{data_i, data_par_i}) && !rst_cmd) |=> atn_o);

  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

bind scsi_init_xfer scsi_init_xfer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/scsi_init_xfer_test.sv
module scsi_init_xfer_test;
  localparam int RST_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_wr = 0, parity_en = 0, rst_irq_dis = 0, atn_set = 0, stat_rd = 0;
  logic [7:0]  cmd = 0;
  logic [15:0] cmd_cnt = 0;
  logic        req = 0, msg = 0, cd = 0, io = 0, dpar = 0;
  logic [7:0]  din = 0;
  logic        ack, atn, rst_bus, dpar_o, oe, push, pop, irq;
  logic [7:0]  dout, wdata, cmd_reg;
  logic [3:0]  status;
  logic [7:0]  rdat;
  logic [4:0]  lvl;
  logic        empty;

  int vectors = 0, fails = 0;

  // FIFO model
  logic [7:0] tx_mem [16];
  logic [7:0] rx_mem [16];
  int tx_wr = 0, tx_rd = 0, rx_cnt = 0;
  logic pop_seen = 0, push_seen = 0;
  logic [7:0] push_dat = 0;

  assign rdat  = tx_mem[tx_rd % 16];
  assign lvl   = 5'(tx_wr - tx_rd);
  assign empty = (tx_wr == tx_rd);

  always @(posedge clk) begin
    pop_seen  <= pop;
    push_seen <= push;
    push_dat  <= wdata;
  end
  always @(negedge clk) begin
    if (pop_seen) tx_rd = tx_rd + 1;
    if (push_seen) begin rx_mem[rx_cnt % 16] = push_dat; rx_cnt = rx_cnt + 1; end
  end

  scsi_init_xfer #(.RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .cmd_count_i(cmd_cnt), .parity_en_i(parity_en), .rst_irq_dis_i(rst_irq_dis),
    .atn_set_i(atn_set), .status_rd_i(stat_rd), .req_i(req), .msg_i(msg),
    .cd_i(cd), .io_i(io), .data_i(din), .data_par_i(dpar), .ack_o(ack),
    .atn_o(atn), .rst_bus_o(rst_bus), .data_o(dout), .data_par_o(dpar_o),
    .data_oe_o(oe), .fifo_push_o(push), .fifo_wdata_o(wdata), .fifo_pop_o(pop),
    .fifo_rdata_i(rdat), .fifo_empty_i(empty), .fifo_level_i(lvl),
    .cmd_reg_o(cmd_reg), .status_o(status), .irq_o(irq)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt line against the cause vector
  always @(negedge clk) if (rst_n) check(irq === (status != 4'h0), "R12 irq", irq, status != 4'h0);

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    summary();
    $finish;
  end

  logic prev_atn = 0;

  task automatic wr_cmd(input logic [7:0] c, input logic [15:0] n);
    @(negedge clk); cmd = c; cmd_cnt = n; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic set_ph(input logic [2:0] p);
    {msg, cd, io} = p;
  endtask

  task automatic wait_ack(input logic v, input string r);
    int n = 0;
    prev_atn = atn;
    while (ack !== v && n < 40) begin prev_atn = atn; @(negedge clk); n++; end
    check(ack === v, r, ack, v);
  endtask

  task automatic t_in(input logic [2:0] p, input logic [7:0] b, input bit bad, input bit hold);
    @(negedge clk); set_ph(p); din = b; dpar = ~(^b) ^ bad; req = 1;
    wait_ack(1, "R3 ack rise");
    @(negedge clk); req = 0;
    if (!hold) wait_ack(0, "R3 ack fall");
  endtask

  task automatic t_out(input logic [2:0] p, input logic [7:0] e);
    @(negedge clk); set_ph(p); req = 1;
    wait_ack(1, "R4 ack rise");
    check(dout === e, "R4 data", dout, e);
    check(dpar_o === ~(^e), "R4 parity", dpar_o, ~(^e));
    check(oe === 1'b1, "R4 oe", oe, 1);
    @(negedge clk); req = 0;
    wait_ack(0, "R4 ack fall");
  endtask

  task automatic tgt_req_status();
    @(negedge clk); set_ph(3'b011); req = 1;
    @(negedge clk); @(negedge clk);
    req = 0;
  endtask

  task automatic do_reset(input bit dis, input string r);
    int n = 0;
    rst_irq_dis = dis;
    wr_cmd(8'h03, 0);
    check(ack === 0 && oe === 0 && atn === 0, r, {ack, oe, atn}, 0);
    while (rst_bus === 1'b1 && n < 100) begin n++; @(negedge clk); end
    check(n == RST_CYC, "R11 reset length", n, RST_CYC);
    check(cmd_reg === 8'h00, "R11 cmd cleared", cmd_reg, 0);
    check(status[2] === !dis, "R11 reset bit", status[2], !dis);
    rst_irq_dis = 0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check({ack, atn, rst_bus, oe, push, pop, irq} === 7'b0, "R1 outputs", {ack, atn, rst_bus, oe, push, pop, irq}, 0);
    check(cmd_reg === 8'h00 && status === 4'h0, "R1 regs", {cmd_reg, status}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 unknown code ignored
    wr_cmd(8'h55, 0);
    check(cmd_reg === 8'h00, "R2 bad code", cmd_reg, 0);

    // DMA data in, three bytes
    base = rx_cnt;
    wr_cmd(8'h90, 3);
    check(cmd_reg === 8'h90, "R2 accept", cmd_reg, 8'h90);
    t_in(3'b001, 8'hA1, 0, 0);
    wr_cmd(8'h10, 0);
    check(cmd_reg === 8'h90, "R2 busy ignore", cmd_reg, 8'h90);
    t_in(3'b001, 8'h5B, 0, 0);
    t_in(3'b001, 8'hC3, 0, 0);
    check(cmd_reg === 8'h00, "R5 dma count end", cmd_reg, 0);
    check(status === 4'h0, "R7 no irq before REQ", status, 0);
    tgt_req_status();
    check(status === 4'b0010, "R7 service on REQ", status, 4'b0010);
    repeat (2) @(negedge clk);
    check(rx_cnt - base == 3, "R3 push count", rx_cnt - base, 3);
    check(rx_mem[base % 16] === 8'hA1 && rx_mem[(base + 2) % 16] === 8'hC3, "R3 push data",
          rx_mem[(base + 2) % 16], 8'hC3);
    rd_stat();
    check(status === 4'h0, "R12 read clears", status, 0);

    // non-DMA data out, FIFO holds two bytes
    tx_mem[tx_wr % 16] = 8'h3C; tx_wr++;
    tx_mem[tx_wr % 16] = 8'hA5; tx_wr++;
    wr_cmd(8'h10, 0);
    t_out(3'b000, 8'h3C);
    check(cmd_reg === 8'h10, "R5 not last at level 2", cmd_reg, 8'h10);
    t_out(3'b000, 8'hA5);
    check(cmd_reg === 8'h00, "R5 fifo level end", cmd_reg, 0);
    check(oe === 1'b0, "R4 oe off", oe, 0);
    tgt_req_status();
    check(status === 4'b0010, "R7 service out", status, 4'b0010);
    rd_stat();

    // Message Out, last byte, FIFO starts empty
    @(negedge clk); atn_set = 1;
    @(negedge clk); atn_set = 0;
    check(atn === 1'b1, "R8 atn set", atn, 1);
    wr_cmd(8'h90, 1);
    @(negedge clk); set_ph(3'b110); req = 1;
    repeat (4) @(negedge clk);
    check(ack === 1'b0, "R4 stall on empty", ack, 0);
    tx_mem[tx_wr % 16] = 8'h0C; tx_wr++;
    wait_ack(1, "R8 ack rise");
    check(prev_atn === 1'b0, "R8 atn low cycle before ack", prev_atn, 0);
    check(atn === 1'b0, "R8 atn low at ack", atn, 0);
    check(dout === 8'h0C, "R4 msg byte", dout, 8'h0C);
    @(negedge clk); req = 0;
    wait_ack(0, "R8 ack fall");
    @(negedge clk); set_ph(3'b111); req = 1;
    @(negedge clk); @(negedge clk); req = 0;
    check(status === 4'b0010, "R7 service after msg out", status, 4'b0010);
    rd_stat();

    // Message In, non-DMA, one byte
    wr_cmd(8'h10, 0);
    t_in(3'b111, 8'h07, 0, 1);
    repeat (5) @(negedge clk);
    check(ack === 1'b1, "R9 ack held", ack, 1);
    check(status === 4'b0001, "R9 success", status, 4'b0001);
    check(cmd_reg === 8'h00, "R9 cmd cleared", cmd_reg, 0);
    wr_cmd(8'h10, 0);
    check(ack === 1'b0, "R9 ack released", ack, 0);
    do_reset(1, "R11 abort idle");
    rd_stat();

    // parity checking enabled
    parity_en = 1;
    wr_cmd(8'h90, 2);
    @(negedge clk); set_ph(3'b001); din = 8'h81; dpar = ~(^din) ^ 1'b1; req = 1;
    wait_ack(1, "R10 ack rise");
    check(atn === 1'b1, "R10 atn with ack", atn, 1);
    @(negedge clk); req = 0;
    wait_ack(0, "R10 ack fall");
    check(status[3] === 1'b1, "R10 parity bit", status[3], 1);
    t_in(3'b001, 8'h42, 0, 0);
    do_reset(0, "R11 abort done");
    rd_stat();

    // parity checking disabled
    parity_en = 0;
    wr_cmd(8'h90, 1);
    t_in(3'b001, 8'h81, 1, 0);
    check(atn === 1'b0, "R10 disabled atn", atn, 0);
    check(status[3] === 1'b0, "R10 disabled bit", status[3], 0);
    do_reset(0, "R11 abort 2");
    rd_stat();

    // early phase change
    base = rx_cnt;
    wr_cmd(8'h90, 3);
    t_in(3'b001, 8'h11, 0, 0);
    @(negedge clk); set_ph(3'b011); din = 8'hEE; dpar = ~(^din); req = 1;
    repeat (3) @(negedge clk);
    check(ack === 1'b0, "R6 no ack", ack, 0);
    check(cmd_reg === 8'h00, "R6 cmd cleared", cmd_reg, 0);
    check(status === 4'b0010, "R6 service", status, 4'b0010);
    req = 0;
    repeat (2) @(negedge clk);
    check(rx_cnt - base == 1, "R6 no push", rx_cnt - base, 1);
    rd_stat();

    // bus reset during a handshake
    wr_cmd(8'h90, 5);
    @(negedge clk); set_ph(3'b001); din = 8'h22; dpar = ~(^din); req = 1;
    wait_ack(1, "R11 pre ack");
    do_reset(0, "R11 mid handshake");
    req = 0;
    rd_stat();
    check(status === 4'h0, "R12 final clear", status, 0);

    summary();
    $finish;
  end
endmodule